// File: doc/BRIEF.md
# Codec Link Reset and Presence Sequencer

This block owns the reset state of a serial codec link and records which codecs announce themselves on it. Software controls it through two 16-bit registers: a link control register and a codec status register. Clearing the run bit in the control register forces the link into reset. Setting the run bit starts a timed release: the link is first held in reset until the codec clocks have had time to settle, and is then released. The block then waits out the codec start-up window before it reports the link as up. The run bit does not read back the value written to it. It reads back whether the link is actually up.

While the link is out of reset, each codec drives a presence line high to announce itself. Any high presence line sets a sticky bit in the status register. Software clears these bits by writing one to them. A second control bit enables acceptance of unsolicited responses and goes directly to an output. All timing counts pulses of a one-microsecond tick input, so the block works at any clock rate.

Top module: `lrs_link_ctrl`

## Requirements
- R1: After synchronous reset, the control register reads 0x0000, the status register reads 0x0000 and `link_reset_o` is 1.
- R2: A control write with bit 0 equal to 0 while the link is up drives `link_reset_o` to 1, and bit 0 reads 0 from the next cycle on.
- R3: After a control write with bit 0 equal to 1, `link_reset_o` stays 1 until at least SETTLE_US ticks have been counted since the link last entered reset. An earlier request is held and carried out later.
- R4: Once `link_reset_o` falls, control bit 0 reads 1 only after WAKE_US further ticks. Until then it reads 0.
- R5: A control write with bit 0 equal to 0 during the release window aborts it. `link_reset_o` returns to 1 on the next cycle, and a new release again needs SETTLE_US ticks in reset.
- R6: While `link_reset_o` is 1, the presence inputs are ignored. While it is 0 (release window or link up), a high presence line i sets status bit i.
- R7: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. If presence is high for a bit in the same cycle, the bit stays set.
- R8: Status bits at and above NUM_CODECS (15 by default, so bit 15) always read 0. Control bits other than 0 and 8 always read 0.
- R9: Control bit 8 is the unsolicited-response enable. It reads back as written, drives `unsol_accept_o`, and does not affect the link state.
- R10: The timers advance only on cycles where `us_tick` is 1. With the tick held low, neither release phase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status (write and read) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| codec_present | input | NUM_CODECS | Per-codec presence lines |
| link_reset_o | output | 1 | 1 while the link is held in reset |
| unsol_accept_o | output | 1 | Unsolicited-response enable |

## Verification
Several rules are checked by assertions on every cycle:
- The release never begins before the settle timer has finished, and the link is never reported up before the start-up timer has finished.
- A write that clears the run bit always lands the sequencer in reset on the next cycle.
- No status bit becomes newly set while the link is in reset.
- A written-one status bit with no presence pending is cleared.
- The timer holds still without a tick.

Only the bench scenarios can show the actual durations seen at the ports. They also show:
- that a pending request survives the settle period;
- that an abort restarts the settle period;
- that set wins over clear in the same cycle;
- the read-back layout of both registers.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int REG_W         = 16;
    localparam int MAX_CODECS    = 15;
    localparam int CTL_RUN_BIT   = 0;
    localparam int CTL_UNSOL_BIT = 8;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_STS = 1'b1;

    typedef enum logic [1:0] {
        LNK_HELD = 2'd0,
        LNK_EXIT = 2'd1,
        LNK_UP   = 2'd2
    } lnk_state_e;

    typedef struct packed {
        logic             ctl_we;
        logic             sts_we;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    function automatic logic [REG_W-1:0] pack_ctl(input logic up, input logic unsol);
        logic [REG_W-1:0] v;
        v = '0;
        v[CTL_RUN_BIT]   = up;
        v[CTL_UNSOL_BIT] = unsol;
        return v;
    endfunction

endpackage

// File: rtl/lrs_tick_timer.sv
module lrs_tick_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt <= '0;
        end else if (tick_i && (cnt < limit_i)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done_o = (cnt >= limit_i);

    // R10: without a tick and without a clear the count must not move
    assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_i) |=> $stable(cnt));

endmodule

// File: rtl/lrs_seq_fsm.sv
module lrs_seq_fsm
    import lrs_pkg::*;
#(
    parameter int SETTLE_US = 100,
    parameter int WAKE_US   = 540,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we_i,
    input  logic             run_bit_i,
    input  logic             tmr_done_i,
    output logic             tmr_clr_o,
    output logic [CNT_W-1:0] tmr_limit_o,
    output lnk_state_e       state_o
);
    lnk_state_e state, state_nx;
    logic       run_req;
    logic       stop_wr;

    assign stop_wr = ctl_we_i && !run_bit_i;

    always_comb begin
        state_nx  = state;
        tmr_clr_o = 1'b0;
        case (state)
            LNK_HELD: begin
                if (run_req && tmr_done_i) begin
                    state_nx  = LNK_EXIT;
                    tmr_clr_o = 1'b1;
                end
            end
            LNK_EXIT: begin
                if (tmr_done_i) state_nx = LNK_UP;
            end
            LNK_UP:   state_nx = LNK_UP;
            default:  state_nx = LNK_HELD;
        endcase
        if (stop_wr) begin
            state_nx  = LNK_HELD;
            tmr_clr_o = (state != LNK_HELD);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LNK_HELD;
            run_req <= 1'b0;
        end else begin
            state <= state_nx;
            if (ctl_we_i) run_req <= run_bit_i;
        end
    end

    assign tmr_limit_o = (state == LNK_HELD) ? CNT_W'(SETTLE_US) : CNT_W'(WAKE_US);
    assign state_o     = state;

    // R3: release begins only once the settle timer reported completion
    assert_exit_after_settle_R3: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_EXIT && $past(state) == LNK_HELD) |-> $past(tmr_done_i));

    // R4: link reported up only once the start-up timer reported completion
    assert_up_after_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_UP && $past(state) == LNK_EXIT) |-> $past(tmr_done_i));

    // R5: a stop write always lands in reset
    assert_stop_enters_reset_R5: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> (state == LNK_HELD));

endmodule

// File: rtl/lrs_presence_latch.sv
module lrs_presence_latch #(
    parameter int NUM_CODECS = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_en_i,
    input  logic [NUM_CODECS-1:0] present_i,
    input  logic                  clr_we_i,
    input  logic [NUM_CODECS-1:0] clr_mask_i,
    output logic [NUM_CODECS-1:0] sts_o
);
    logic [NUM_CODECS-1:0] sts;

    for (genvar i = 0; i < NUM_CODECS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                sts[i] <= 1'b0;
            end else if (sample_en_i && present_i[i]) begin
                sts[i] <= 1'b1;
            end else if (clr_we_i && clr_mask_i[i]) begin
                sts[i] <= 1'b0;
            end
        end
    end

    assign sts_o = sts;

    // R6: nothing newly set while the link is held in reset
    assert_no_set_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
        !sample_en_i |=> ((sts & ~$past(sts)) == '0));

    // R7: written ones clear when no presence is being sampled
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_we_i && !sample_en_i) |=> ((sts & $past(clr_mask_i)) == '0));

endmodule

// File: rtl/lrs_link_ctrl.sv
module lrs_link_ctrl
    import lrs_pkg::*;
#(
    parameter int NUM_CODECS = 15,
    parameter int SETTLE_US  = 100,
    parameter int WAKE_US    = 540
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  us_tick,
    input  logic                  reg_we,
    input  logic                  reg_addr,
    input  logic [15:0]           reg_wdata,
    output logic [15:0]           reg_rdata,
    input  logic [NUM_CODECS-1:0] codec_present,
    output logic                  link_reset_o,
    output logic                  unsol_accept_o
);
    localparam int MAX_US = (SETTLE_US > WAKE_US) ? SETTLE_US : WAKE_US;
    localparam int CNT_W  = $clog2(MAX_US + 1);
    localparam int NC     = (NUM_CODECS > MAX_CODECS) ? MAX_CODECS : NUM_CODECS;

    reg_wr_t               wr;
    lnk_state_e            state;
    logic                  tmr_clr, tmr_done;
    logic [CNT_W-1:0]      tmr_limit;
    logic                  unsol_q;
    logic [NUM_CODECS-1:0] sts;
    logic [NUM_CODECS-1:0] sts_vis;
    logic [REG_W-1:0]      sts_word;

    always_comb begin
        wr.ctl_we = reg_we && (reg_addr == ADDR_CTL);
        wr.sts_we = reg_we && (reg_addr == ADDR_STS);
        wr.data   = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unsol_q <= 1'b0;
        end else if (wr.ctl_we) begin
            unsol_q <= wr.data[CTL_UNSOL_BIT];
        end
    end

    lrs_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (tmr_clr),
        .tick_i  (us_tick),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    lrs_seq_fsm #(
        .SETTLE_US (SETTLE_US),
        .WAKE_US   (WAKE_US),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ctl_we_i    (wr.ctl_we),
        .run_bit_i   (wr.data[CTL_RUN_BIT]),
        .tmr_done_i  (tmr_done),
        .tmr_clr_o   (tmr_clr),
        .tmr_limit_o (tmr_limit),
        .state_o     (state)
    );

    lrs_presence_latch #(.NUM_CODECS(NUM_CODECS)) u_pres (
        .clk         (clk),
        .rst         (rst),
        .sample_en_i (state != LNK_HELD),
        .present_i   (codec_present),
        .clr_we_i    (wr.sts_we),
        .clr_mask_i  (wr.data[NUM_CODECS-1:0]),
        .sts_o       (sts)
    );

    for (genvar i = 0; i < NUM_CODECS; i++) begin : g_vis
        if (i < NC) begin : g_on
            assign sts_vis[i] = sts[i];
        end else begin : g_off
            assign sts_vis[i] = 1'b0;
        end
    end

    always_comb begin
        sts_word = '0;
        sts_word[NUM_CODECS-1:0] = sts_vis;
    end

    assign reg_rdata      = (reg_addr == ADDR_CTL) ? pack_ctl(state == LNK_UP, unsol_q) : sts_word;
    assign link_reset_o   = (state == LNK_HELD);
    assign unsol_accept_o = unsol_q;

    // R4: an up link is never in reset
    assert_up_not_in_reset_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[CTL_RUN_BIT] && (reg_addr == ADDR_CTL) |-> !link_reset_o);

    // R8: the top status bit never reads set
    assert_top_bit_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STS) |-> (reg_rdata[REG_W-1] == 1'b0));

endmodule

// File: tb/tb_lrs_link_ctrl.sv
module tb_lrs_link_ctrl;
    localparam int NC     = 15;
    localparam int SETTLE = 100;
    localparam int WAKE   = 540;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b1;
    logic          reg_we = 1'b0;
    logic          reg_addr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NC-1:0] pres = '0;
    logic          link_reset_o, unsol_accept_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lrs_link_ctrl #(.NUM_CODECS(NC), .SETTLE_US(SETTLE), .WAKE_US(WAKE)) dut (
        .clk(clk), .rst(rst), .us_tick(tick_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .codec_present(pres),
        .link_reset_o(link_reset_o), .unsol_accept_o(unsol_accept_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pres = '0; tick_en = 1'b1; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_link_low(output int n);
        n = 0;
        while (link_reset_o && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_up(output int n);
        logic [15:0] v;
        n = 0;
        rd(1'b0, v);
        while (!v[0] && n < 3000) begin @(negedge clk); n++; rd(1'b0, v); end
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        do_reset();
        rd(1'b0, v); chk(v == 16'h0, "R1 ctl", v, 0);
        rd(1'b1, v); chk(v == 16'h0, "R1 sts", v, 0);
        chk(link_reset_o == 1'b1, "R1 link_reset", link_reset_o, 1);
    endtask

    task automatic t_release_timing();
        int n;
        logic [15:0] v;
        do_reset();
        wr(1'b0, 16'h0001);
        chk(link_reset_o == 1'b1, "R3 held right after request", link_reset_o, 1);
        wait_link_low(n);
        chk(n >= SETTLE - 5 && n <= SETTLE + 3, "R3 settle duration", n, SETTLE);
        rd(1'b0, v); chk(v[0] == 1'b0, "R4 not up at release", v[0], 0);
        wait_up(n);
        chk(n >= WAKE - 2 && n <= WAKE + 3, "R4 wake duration", n, WAKE);
        chk(link_reset_o == 1'b0, "R4 link released when up", link_reset_o, 0);
        wr(1'b0, 16'h0000);
        chk(link_reset_o == 1'b1, "R2 link in reset", link_reset_o, 1);
        rd(1'b0, v); chk(v[0] == 1'b0, "R2 bit reads 0", v[0], 0);
    endtask

    task automatic t_tick_gate();
        int n;
        logic [15:0] v;
        do_reset();
        wr(1'b0, 16'h0001);
        wait_link_low(n);
        tick_en = 1'b0;
        repeat (WAKE + 100) @(negedge clk);
        rd(1'b0, v); chk(v[0] == 1'b0, "R10 no progress without tick", v[0], 0);
        tick_en = 1'b1;
        wait_up(n);
        chk(n >= WAKE - 3 && n <= WAKE + 3, "R10 full wait after tick resumes", n, WAKE);
    endtask

    task automatic t_abort();
        int n;
        logic [15:0] v;
        do_reset();
        wr(1'b0, 16'h0001);
        wait_link_low(n);
        repeat (200) @(negedge clk);
        wr(1'b0, 16'h0000);
        chk(link_reset_o == 1'b1, "R5 abort to reset", link_reset_o, 1);
        rd(1'b0, v); chk(v[0] == 1'b0, "R5 bit 0 after abort", v[0], 0);
        wr(1'b0, 16'h0001);
        wait_link_low(n);
        chk(n >= SETTLE - 3 && n <= SETTLE + 3, "R5 settle restarts", n, SETTLE);
    endtask

    task automatic t_presence();
        int n;
        logic [15:0] v;
        do_reset();
        pres = '1;
        repeat (3) @(negedge clk);
        pres = '0;
        @(negedge clk);
        rd(1'b1, v); chk(v == 16'h0, "R6 ignored in reset", v, 0);
        wr(1'b0, 16'h0001);
        wait_link_low(n);
        pres = 15'h0005; @(negedge clk); pres = '0;
        rd(1'b1, v); chk(v == 16'h0005, "R6 latched in release window", v, 5);
        wr(1'b1, 16'h0001);
        rd(1'b1, v); chk(v == 16'h0004, "R7 clear one bit", v, 4);
        wr(1'b1, 16'h0000);
        rd(1'b1, v); chk(v == 16'h0004, "R7 zero write keeps", v, 4);
        pres = 15'h0004; wr(1'b1, 16'h0004); pres = '0;
        rd(1'b1, v); chk(v == 16'h0004, "R7 set wins over clear", v, 4);
        wr(1'b1, 16'h0004);
        rd(1'b1, v); chk(v == 16'h0000, "R7 cleared", v, 0);
        pres = '1; @(negedge clk); pres = '0;
        rd(1'b1, v); chk(v == 16'h7FFF, "R8 status width", v, 16'h7FFF);
        wait_up(n);
        pres = 15'h0100; @(negedge clk); pres = '0;
        rd(1'b1, v); chk(v == 16'h7FFF, "R6 wake while up keeps set", v, 16'h7FFF);
        wr(1'b1, 16'hFFFF);
        pres = 15'h0200; @(negedge clk); pres = '0;
        rd(1'b1, v); chk(v == 16'h0200, "R6 wake while up", v, 16'h0200);
    endtask

    task automatic t_unsol();
        logic [15:0] v;
        do_reset();
        wr(1'b0, 16'h0100);
        chk(unsol_accept_o == 1'b1, "R9 unsol output", unsol_accept_o, 1);
        rd(1'b0, v); chk(v == 16'h0100, "R9 ctl readback", v, 16'h0100);
        repeat (SETTLE + 20) @(negedge clk);
        chk(link_reset_o == 1'b1, "R9 link unaffected", link_reset_o, 1);
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); chk((v & 16'hFEFE) == 16'h0, "R8 unused ctl bits", v, 0);
        wr(1'b0, 16'h0001);
        chk(unsol_accept_o == 1'b0, "R9 unsol cleared", unsol_accept_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_release_timing();
        t_tick_gate();
        t_abort();
        t_presence();
        t_unsol();
        summary();
    end
endmodule